// File: doc/BRIEF.md
# Flash Status Poller

This block sits on the host side of a parallel NOR flash. It watches the flash while the flash runs its own program or erase routine. After the command sequence has been written elsewhere, the host pulses `start` and supplies four things: the byte being programmed, the method, the operation type and a poll budget. The poller then issues single-byte reads through a request/valid port. The address comes from outside and stays on one valid location. It decodes each returned status byte and finishes with exactly one result: completed, device-reported time limit, poll budget exhausted, or erase suspended. That result and the last byte read stay on the outputs until the next accepted start.

The method is set by `use_toggle`.
- In complement polling, bit 7 is compared with the expected data. For an erase, the byte must equal FFh.
- In toggle checking, each read is compared with the one before it. Bit 6 shows whether the device is still busy. Bit 2 separates a suspended erase sector from one that has finished.

When bit 5 (the device time-limit bit) is seen, one further read is taken before any failure is declared. This is needed because the status bits can change in the same read.

States are `ST_IDLE`, `ST_REQ`, `ST_WAIT`, `ST_RCHK_REQ` and `ST_RCHK_WAIT`. The transitions are:
- IDLE→REQ on start.
- REQ→WAIT always.
- WAIT→IDLE on suspend, completion or budget exhaustion.
- WAIT→RCHK_REQ on bit 5.
- WAIT→REQ on a plain busy read.
- RCHK_REQ→RCHK_WAIT always.
- RCHK_WAIT→IDLE on the recheck byte.

Top module: `flash_status_poller`

## Requirements
- R1: After reset `busy`, `rd_req`, all four result flags and `last_data` are 0.
- R2: `start` is accepted only while `busy` is 0. Accepting it clears all result flags and latches mode, operation, expected byte and budget. A `start` while `busy` is 1 has no effect on the run.
- R3: `rd_req` is a one-cycle pulse. The next request is raised only after `rd_valid` has been seen in a waiting state. `rd_valid` outside a waiting state is ignored, and so is `rd_data` with it.
- R4: Program, complement polling: a read whose bit 7 equals bit 7 of `expect_byte` completes the run (`done_ok`).
- R5: Erase, complement polling: a read equal to FFh completes the run.
- R6: Toggle checking (from the second read on): program completes when bit 6 equals bit 6 of the previous read. Erase additionally needs bit 2 unchanged and the byte equal to FFh.
- R7: Erase only, from the second read on: bit 7 = 1, bit 6 unchanged and bit 2 changed versus the previous read gives `suspended`. This test is made before the completion test.
- R8: A read that is neither complete nor suspended but has bit 5 = 1 causes exactly one more read. That read is judged for completion against the bit-5 read: complete gives `done_ok`, otherwise `fail_limit`.
- R9: If no read completes, suspends or shows bit 5 within `max_polls` reads, `fail_timeout` is raised after the last of them. A budget of 0 acts as 1, and the recheck read is not counted.
- R10: In one read, completion and suspension take priority over bit 5, and bit 5 takes priority over budget exhaustion.
- R11: At most one result flag is high. The flags and `last_data` (the most recently accepted byte) hold until the next accepted start.
- R12: `busy` is 1 from the cycle after an accepted start until the edge that sets the result flag, when it drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| use_toggle | input | 1 | 0 = bit-7 complement polling, 1 = toggle checking |
| op_erase | input | 1 | 0 = program, 1 = erase |
| expect_byte | input | 8 | Byte being programmed |
| max_polls | input | CNT_W | Poll budget (0 treated as 1) |
| rd_req | output | 1 | One-cycle read request |
| rd_data | input | 8 | Status byte returned by the flash |
| rd_valid | input | 1 | `rd_data` is valid |
| busy | output | 1 | Run in progress |
| done_ok | output | 1 | Operation completed |
| fail_limit | output | 1 | Device time limit confirmed by recheck |
| fail_timeout | output | 1 | Poll budget used up |
| suspended | output | 1 | Erase-suspended sector detected |
| last_data | output | 8 | Last byte accepted |

## Verification
Three decisions can meet on a single read. The byte can carry bit 5 while also meeting the completion rule. It can carry bit 5 on the read that uses up the budget. A suspended-sector pattern can also reach FFh. Scripted flash responses provoke each of these: a completing byte with bit 5 set, a bit-5 read placed on the final budgeted poll, and alternating bit-2 bytes. A reference walk of the requirement rules over the same script predicts the result flag, the number of read requests and the final byte, and each of these is compared after the run.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int BYTE_W = 8;
    localparam int B_POLL = 7;   // complement-of-data bit
    localparam int B_TOG  = 6;   // toggles on every read while busy
    localparam int B_LIM  = 5;   // device time limit exceeded
    localparam int B_SECT = 2;   // toggles on sectors selected for erase

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_RCHK_REQ,
        ST_RCHK_WAIT
    } poll_state_t;

    typedef enum logic [1:0] {
        RES_DONE,
        RES_LIMIT,
        RES_TIMEOUT,
        RES_SUSP
    } poll_res_t;
endpackage

// File: rtl/fsp_status_decode.sv
module fsp_status_decode
    import fsp_pkg::*;
(
    input  logic [BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0] prev,
    input  logic              have_prev,
    input  logic              use_toggle,
    input  logic              op_erase,
    input  logic [BYTE_W-1:0] expect_byte,
    output logic              complete,
    output logic              susp_seen,
    output logic              limit_seen
);
    logic tog6, tog2, all_ones;

    always_comb begin
        tog6     = have_prev && (cur[B_TOG]  != prev[B_TOG]);
        tog2     = have_prev && (cur[B_SECT] != prev[B_SECT]);
        all_ones = &cur;
        if (use_toggle)
            complete = have_prev && !tog6 && (!op_erase || (!tog2 && all_ones));
        else
            complete = op_erase ? all_ones : (cur[B_POLL] == expect_byte[B_POLL]);
        susp_seen  = op_erase && have_prev && cur[B_POLL] && !tog6 && tog2;
        limit_seen = cur[B_LIM];
    end
endmodule

// File: rtl/fsp_poll_budget.sv
module fsp_poll_budget #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] limit,
    input  logic             step,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, lim_q, eff;

    assign eff  = (lim_q == '0) ? ONE : lim_q;
    assign last = ({1'b0, cnt_q} + {1'b0, ONE}) >= {1'b0, eff};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= limit;
        end else if (step) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R9: the controller never continues polling once the budget is spent
    a_r9_step_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);
    // R9: the count stays below the effective budget
    a_r9_cnt_below_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < eff) || (lim_q == '0 && cnt_q == '0));
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fsp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_toggle,
    input  logic              op_erase,
    input  logic [7:0]        expect_byte,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              rd_req,
    input  logic [7:0]        rd_data,
    input  logic              rd_valid,
    output logic              busy,
    output logic              done_ok,
    output logic              fail_limit,
    output logic              fail_timeout,
    output logic              suspended,
    output logic [7:0]        last_data
);
    poll_state_t state_q, state_n;

    logic [BYTE_W-1:0] prev_q, last_q, exp_q;
    logic              have_prev_q, tog_q, erase_q;
    logic              done_q, lim_q, tmo_q, sus_q;
    logic              is_complete, is_susp, is_limit, budget_last;
    logic              launch, step, fin, accept;
    poll_res_t         fin_res;

    assign launch = (state_q == ST_IDLE) && start;
    assign accept = rd_valid && ((state_q == ST_WAIT) || (state_q == ST_RCHK_WAIT));

    fsp_status_decode u_dec (
        .cur        (rd_data),
        .prev       (prev_q),
        .have_prev  (have_prev_q),
        .use_toggle (tog_q),
        .op_erase   (erase_q),
        .expect_byte(exp_q),
        .complete   (is_complete),
        .susp_seen  (is_susp),
        .limit_seen (is_limit)
    );

    fsp_poll_budget #(.CNT_W(CNT_W)) u_bud (
        .clk  (clk),
        .rst_n(rst_n),
        .load (launch),
        .limit(max_polls),
        .step (step),
        .last (budget_last)
    );

    // Next state and per-read decision
    always_comb begin
        state_n = state_q;
        step    = 1'b0;
        fin     = 1'b0;
        fin_res = RES_DONE;
        unique case (state_q)
            ST_IDLE: if (start) state_n = ST_REQ;
            ST_REQ:  state_n = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    if (is_susp) begin
                        fin = 1'b1; fin_res = RES_SUSP;
                    end else if (is_complete) begin
                        fin = 1'b1; fin_res = RES_DONE;
                    end else if (is_limit) begin
                        state_n = ST_RCHK_REQ;
                    end else if (budget_last) begin
                        fin = 1'b1; fin_res = RES_TIMEOUT;
                    end else begin
                        step = 1'b1; state_n = ST_REQ;
                    end
                end
            end
            ST_RCHK_REQ: state_n = ST_RCHK_WAIT;
            ST_RCHK_WAIT: begin
                if (rd_valid) begin
                    fin     = 1'b1;
                    fin_res = is_complete ? RES_DONE : RES_LIMIT;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (fin) state_n = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Output and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= '0;
            last_q      <= '0;
            exp_q       <= '0;
            have_prev_q <= 1'b0;
            tog_q       <= 1'b0;
            erase_q     <= 1'b0;
            done_q      <= 1'b0;
            lim_q       <= 1'b0;
            tmo_q       <= 1'b0;
            sus_q       <= 1'b0;
        end else begin
            if (launch) begin
                exp_q       <= expect_byte;
                tog_q       <= use_toggle;
                erase_q     <= op_erase;
                have_prev_q <= 1'b0;
                done_q      <= 1'b0;
                lim_q       <= 1'b0;
                tmo_q       <= 1'b0;
                sus_q       <= 1'b0;
            end
            if (accept) begin
                last_q      <= rd_data;
                prev_q      <= rd_data;
                have_prev_q <= 1'b1;
            end
            if (fin) begin
                done_q <= (fin_res == RES_DONE);
                lim_q  <= (fin_res == RES_LIMIT);
                tmo_q  <= (fin_res == RES_TIMEOUT);
                sus_q  <= (fin_res == RES_SUSP);
            end
        end
    end

    assign rd_req       = (state_q == ST_REQ) || (state_q == ST_RCHK_REQ);
    assign busy         = (state_q != ST_IDLE);
    assign done_ok      = done_q;
    assign fail_limit   = lim_q;
    assign fail_timeout = tmo_q;
    assign suspended    = sus_q;
    assign last_data    = last_q;

    // R11: never more than one result
    a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok, fail_limit, fail_timeout, suspended}));
    // R3: request is a single-cycle pulse
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R11 / R3: idle outputs hold without a start
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({done_ok, fail_limit, fail_timeout, suspended, last_data}));
    // R2: accepted start clears results and raises busy (R12)
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done_ok && !fail_limit && !fail_timeout && !suspended));
    // R8: a device-limit failure only follows the recheck read
    a_r8_limit_after_recheck: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_limit) |-> $past(state_q == ST_RCHK_WAIT));
    // R12: a result appears exactly when busy drops
    a_r12_result_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done_ok || fail_limit || fail_timeout || suspended));
endmodule

// File: tb/flash_status_poller_tb_top.sv
module flash_status_poller_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       use_toggle = 1'b0;
    logic       op_erase = 1'b0;
    logic [7:0] expect_byte = 8'h00;
    logic [7:0] max_polls = 8'd8;
    logic       rd_req;
    logic [7:0] rd_data = 8'h00;
    logic       rd_valid = 1'b0;
    logic       busy, done_ok, fail_limit, fail_timeout, suspended;
    logic [7:0] last_data;

    always #4 clk = ~clk;

    flash_status_poller #(.CNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .use_toggle(use_toggle),
        .op_erase(op_erase), .expect_byte(expect_byte), .max_polls(max_polls),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .done_ok(done_ok), .fail_limit(fail_limit), .fail_timeout(fail_timeout),
        .suspended(suspended), .last_data(last_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] script [0:39];
    int slen = 1;
    int rd_idx = 0;
    int req_count = 0;
    bit inject_req = 0;

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] sget(input int i);
        return (i < slen) ? script[i] : script[slen-1];
    endfunction

    // Flash responder: answers each request one cycle later, in the waiting state
    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rd_req) begin
                req_count++;
                @(negedge clk);
                rd_data  = sget(rd_idx);
                rd_idx++;
                rd_valid = 1'b1;
            end else if (inject_req) begin
                rd_data    = 8'h33;
                rd_valid   = 1'b1;
                inject_req = 0;
            end
        end
    end

    // Reference decisions written from the requirements
    function automatic void ref_eval(input logic tog, input logic er, input logic [7:0] e,
                                     input logic [7:0] c, input logic [7:0] p, input logic hp,
                                     output logic comp, output logic susp);
        logic t6, t2;
        t6 = hp && (c[6] != p[6]);
        t2 = hp && (c[2] != p[2]);
        if (tog) comp = hp && !t6 && (!er || (!t2 && c == 8'hFF));   // R6
        else     comp = er ? (c == 8'hFF) : (c[7] == e[7]);          // R4, R5
        susp = er && hp && c[7] && !t6 && t2;                        // R7
    endfunction

    // Result codes: 0 done, 1 limit, 2 timeout, 3 suspended
    function automatic void ref_run(input logic tog, input logic er, input logic [7:0] e,
                                    input int m, output int res, output int nrd,
                                    output logic [7:0] last);
        int mm, cnt, i;
        logic [7:0] d, p;
        logic hp, comp, susp;
        mm = (m == 0) ? 1 : m; cnt = 0; i = 0; hp = 0; p = 0;
        res = -1; nrd = 0; last = 0;
        while (i < 200) begin
            d = sget(i); i++; last = d;
            ref_eval(tog, er, e, d, p, hp, comp, susp);
            if (susp) begin res = 3; break; end
            if (comp) begin res = 0; break; end
            if (d[5]) begin                                       // R8
                p = d; hp = 1;
                d = sget(i); i++; last = d;
                ref_eval(tog, er, e, d, p, hp, comp, susp);
                res = comp ? 0 : 1;
                break;
            end
            cnt++;
            if (cnt >= mm) begin res = 2; break; end              // R9
            p = d; hp = 1;
        end
        nrd = i;
    endfunction

    function automatic int got_res();
        case ({done_ok, fail_limit, fail_timeout, suspended})
            4'b1000: return 0;
            4'b0100: return 1;
            4'b0010: return 2;
            4'b0001: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic run_case(input string req, input logic tog, input logic er,
                            input logic [7:0] e, input int m, input int poke);
        int exp_res, exp_n, cyc;
        logic [7:0] exp_last;
        ref_run(tog, er, e, m, exp_res, exp_n, exp_last);
        rd_idx = 0; req_count = 0;
        @(negedge clk);
        use_toggle = tog; op_erase = er; expect_byte = e; max_polls = m[7:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12", "busy after start", int'(busy), 1);
        chk("R2", "flags cleared", int'({done_ok, fail_limit, fail_timeout, suspended}), 0);
        cyc = 0;
        while (busy && cyc < 2000) begin
            if (poke != 0 && cyc == poke) begin
                start = 1'b1; use_toggle = ~tog; op_erase = ~er; expect_byte = ~e; max_polls = 8'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= 2000) chk(req, "run hung", 1, 0);
        chk(req, "result code", got_res(), exp_res);
        chk("R3", "read requests", req_count, exp_n);
        chk("R11", "last_data", int'(last_data), int'(exp_last));
    endtask

    task automatic build_prog(input logic [7:0] e, input int n);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = ((e ^ 8'h80) & ~8'h64) | (k[0] ? 8'h40 : 8'h00);
            script[k] = b;
        end
        script[n] = e; slen = n + 1;
    endtask

    function automatic logic [7:0] ebusy(input int k, input logic lim);
        return 8'h08 | (k[0] ? 8'h44 : 8'h00) | (lim ? 8'h20 : 8'h00);
    endfunction

    task automatic build_erase(input int n);
        for (int k = 0; k < n; k++) script[k] = ebusy(k, 0);
        script[n] = 8'hFF; slen = n + 1;
    endtask

    initial begin
        logic [7:0] evals [0:5];
        evals[0] = 8'h00; evals[1] = 8'h80; evals[2] = 8'h5A;
        evals[3] = 8'hA5; evals[4] = 8'hFF; evals[5] = 8'h7F;
        script[0] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "rd_req", int'(rd_req), 0);
        chk("R1", "flags", int'({done_ok, fail_limit, fail_timeout, suspended}), 0);
        chk("R1", "last_data", int'(last_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R6: program in both methods
        for (int t = 0; t < 2; t++)
            for (int ei = 0; ei < 6; ei++)
                for (int n = 0; n < 4; n++) begin
                    build_prog(evals[ei], n);
                    run_case(t ? "R6" : "R4", t[0], 1'b0, evals[ei], 8, 0);
                end

        // R5 / R6: erase in both methods
        for (int t = 0; t < 2; t++)
            for (int n = 0; n < 5; n++) begin
                build_erase(n);
                run_case(t ? "R6" : "R5", t[0], 1'b1, 8'hFF, 8, 0);
            end

        // R8: bit 5 seen, then recheck recovers or fails
        for (int er = 0; er < 2; er++)
            for (int t = 0; t < 2; t++)
                for (int rc = 0; rc < 2; rc++)
                    for (int n = 0; n < 3; n++) begin
                        for (int k = 0; k < n; k++)
                            script[k] = er ? ebusy(k, 0) : (((8'h3C ^ 8'h80) & ~8'h64) | (k[0] ? 8'h40 : 8'h00));
                        script[n] = er ? ebusy(n, 1) : (8'hA0 & ~8'h40) | (n[0] ? 8'h40 : 8'h00);
                        if (rc != 0) script[n+1] = er ? 8'hFF : 8'h3C;
                        else         script[n+1] = er ? ebusy(n + 1, 1) : (8'hA0 & ~8'h40) | (n[0] ? 8'h00 : 8'h40);
                        slen = n + 2;
                        run_case("R8", t[0], er[0], 8'h3C, 8, 0);
                    end

        // R10: completing byte also carries bit 5 -> done
        script[0] = 8'h08; script[1] = 8'hFF; slen = 2;
        run_case("R10", 1'b0, 1'b0, 8'hFF, 8, 0);
        // R10: bit 5 on the final budgeted poll -> recheck, then limit
        script[0] = ebusy(0, 0); script[1] = ebusy(1, 0); script[2] = ebusy(2, 1);
        script[3] = ebusy(3, 1); slen = 4;
        run_case("R10", 1'b0, 1'b1, 8'hFF, 3, 0);
        run_case("R10", 1'b1, 1'b1, 8'hFF, 3, 0);

        // R9: budget exhaustion, including budget 0
        for (int t = 0; t < 2; t++)
            for (int m = 0; m < 6; m++) begin
                for (int k = 0; k < 20; k++) script[k] = ebusy(k, 0);
                slen = 20;
                run_case("R9", t[0], 1'b1, 8'hFF, m, 0);
            end

        // R7: erase-suspended sector, both methods
        for (int t = 0; t < 2; t++) begin
            script[0] = 8'h88; script[1] = 8'h8C; script[2] = 8'h88; slen = 3;
            run_case("R7", t[0], 1'b1, 8'hFF, 8, 0);
        end

        // R2: start while busy is ignored
        build_erase(4);
        run_case("R2", 1'b0, 1'b1, 8'hFF, 8, 3);

        // R3 / R11: stray rd_valid while idle leaves outputs untouched
        begin
            int r0;
            logic [7:0] l0;
            r0 = got_res(); l0 = last_data;
            inject_req = 1;
            repeat (4) @(negedge clk);
            chk("R3", "stray valid result", got_res(), r0);
            chk("R11", "stray valid last_data", int'(last_data), int'(l0));
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule